// File: doc/BRIEF.md
# Fractional-Divider Periodic Interrupt Timer

This block turns a slow, single-cycle tick enable into a periodic interrupt. A lower divider stage counts ticks and emits a base pulse every 100 µs. Because the tick rate is not an integer multiple of that interval, the stage uses a repeating four-step length pattern of 19, 19, 19 and 18 ticks. The 200 µs pulse is taken from every second base pulse, which gives lengths of 38 and 37 ticks in turn. An upper stage counts base pulses to make the longer intervals. A 3-bit selector chooses one of seven intervals, or chooses none.

Software controls the timer through one 8-bit register with a write port and a read port. The register has an enable bit, a write-one clear bit and a sticky interrupt flag. The enable bit pauses and resumes the divider chain without losing its position. The clear bit returns the divider chain to its starting point. The tick source outside the block is not affected by the clear. The interrupt flag is set by hardware and only software can lower it.

Top module: `rt_interval_timer`

## Requirements
- R1: The select field is `ctrl_wdata[2:0]`. Code 0 never raises the flag. Codes 1 to 7 pick 100 µs, 200 µs, 400 µs, 800 µs, 1 ms, 2 ms and 5 ms. Counted from reset, the first intervals are 19, 38, 75, 150, 188, 375 and 938 ticks.
- R2: Starting from reset or clear, the base pulse divider repeats the tick counts 19, 19, 19, 18.
- R3: The 200 µs interval falls on every second base pulse, so its lengths alternate 38 then 37 ticks.
- R4: For codes 3 to 7, the upper stage raises the flag after 4, 8, 10, 20 or 50 base pulses. For codes 0 to 2 it does not count.
- R5: The flag is bit 6. It goes high in the clock cycle that follows the tick that ends an interval, and it stays high while more ticks arrive. A write with bit 6 at 0 clears it. A write with bit 6 at 1 leaves it unchanged.
- R6: A flag-clearing write in the same cycle as an interval expiry leaves the flag at 1.
- R7: The enable bit is bit 4. While it is 0, ticks are ignored and the divider state is held. Setting it to 1 again continues the count from where it stopped.
- R8: Writing 1 to the clear bit (bit 5) resets both divider stages, so the next interval is a full one. Bit 5 always reads as 0.
- R9: Bits 7 and 3 are reserved. They read as 0 and writes to them are ignored.
- R10: After reset, the register reads 0x00 and `irq` is low.
- R11: A write that changes the select code restarts the upper-stage count, so the first interval after the change is a full one of the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Single-cycle tick from the slow time base |
| ctrl_we | input | 1 | Register write strobe |
| ctrl_wdata | input | 8 | Register write data |
| ctrl_rdata | output | 8 | Register read data |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The hardest case to reach from the ports is a flag-clearing write that arrives in the same cycle as the tick that ends an interval. The bench reaches it by counting ticks from reset to one tick before expiry. It then drives the last tick and the clearing write in the same cycle. The upper-stage restart on a select change is also hard to see from outside. The bench leaves a 800 µs interval partly counted, switches to 400 µs, and checks for a full interval that is phase-dependent and measured in ticks. Each code's second interval is also measured, which exposes the alternating lengths of the fractional sequence.

// File: rtl/rtit_pkg.sv
// Shared constants and types for the periodic interrupt timer.
// Assumes an 8-bit control register; positions below are the block's own layout.
package rtit_pkg;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned SEL_W     = 3;
    localparam int unsigned EN_BIT    = 4;
    localparam int unsigned CLR_BIT   = 5;
    localparam int unsigned FLAG_BIT  = 6;
    localparam int unsigned UP_MAX_TC = 50;
    localparam int unsigned UP_W      = $clog2(UP_MAX_TC + 1);

    typedef enum logic [SEL_W-1:0] {
        SEL_OFF  = 3'd0,
        SEL_100U = 3'd1,
        SEL_200U = 3'd2,
        SEL_400U = 3'd3,
        SEL_800U = 3'd4,
        SEL_1M   = 3'd5,
        SEL_2M   = 3'd6,
        SEL_5M   = 3'd7
    } sel_e;

    // Number of base pulses per interval for the upper stage codes.
    function automatic logic [UP_W-1:0] upper_tc(input sel_e s);
        case (s)
            SEL_400U: upper_tc = UP_W'(4);
            SEL_800U: upper_tc = UP_W'(8);
            SEL_1M:   upper_tc = UP_W'(10);
            SEL_2M:   upper_tc = UP_W'(20);
            SEL_5M:   upper_tc = UP_W'(50);
            default:  upper_tc = UP_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/rtit_frac_div.sv
// Lower stage: fractional tick divider.
// Counts ticks in a repeating pattern of SEQ_LEN steps. Every step is BASE_DIV
// ticks long except the last one, which is one tick shorter. p_base fires on the
// tick that ends each step. p_pair fires on every second step end.
// Assumes SEQ_LEN is even and tick_en is a single-cycle strobe.
module rtit_frac_div #(
    parameter int unsigned BASE_DIV = 19,
    parameter int unsigned SEQ_LEN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic run,
    input  logic clr,
    output logic p_base,
    output logic p_pair
);
    localparam int unsigned CNT_W    = $clog2(BASE_DIV);
    localparam int unsigned PH_W     = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam int unsigned SHORT_PH = SEQ_LEN - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [PH_W-1:0]  ph_q;
    logic [CNT_W-1:0] limit;
    logic             step;
    logic             wrap;

    // Pick this step's last count: the final phase is one tick short.
    always_comb begin
        limit = (ph_q == PH_W'(SHORT_PH)) ? CNT_W'(BASE_DIV - 2) : CNT_W'(BASE_DIV - 1);
        step  = tick_en && run && !clr;
        wrap  = step && (cnt_q == limit);
    end

    // Advance the tick count and the sequence phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
            ph_q  <= '0;
        end else if (step) begin
            if (wrap) begin
                cnt_q <= '0;
                ph_q  <= (ph_q == PH_W'(SHORT_PH)) ? '0 : ph_q + PH_W'(1);
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign p_base = wrap;
    assign p_pair = wrap && ph_q[0];

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BASE_DIV - 1));
    a_r2_phase_moves: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (ph_q != $past(ph_q)) && (cnt_q == '0));
    a_r7_paused_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> ($stable(cnt_q) && $stable(ph_q)));
    a_r8_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && ph_q == '0));
endmodule

// File: rtl/rtit_interval_cnt.sv
// Upper stage: counts base pulses up to a selectable terminal count.
// Assumes tc is at least 1 and is stable unless restart is asserted.
module rtit_interval_cnt #(
    parameter int unsigned MAX_TC = 50
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pulse_in,
    input  logic                         run,
    input  logic                         restart,
    input  logic [$clog2(MAX_TC+1)-1:0]  tc,
    output logic                         done
);
    localparam int unsigned CNT_W = $clog2(MAX_TC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             adv;

    // Flag the pulse that completes the interval.
    always_comb begin
        adv  = run && pulse_in && !restart;
        done = adv && (cnt_q == tc - CNT_W'(1));
    end

    // Count pulses, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
        end
    end

    a_r4_below_tc: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < tc);
    a_r11_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == '0);
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/rtit_ctrl_regs.sv
// Control register: enable, select and a sticky flag, plus the write-one clear strobe.
// Assumes set_evt is a single-cycle expiry pulse from the divider chain.
module rtit_ctrl_regs
    import rtit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_evt,
    output logic              en,
    output sel_e              sel,
    output logic              flag,
    output logic              clr_pulse,
    output logic              sel_change,
    output logic [DATA_W-1:0] rd_data
);
    logic   en_q;
    sel_e   sel_q;
    logic   flag_q;
    logic   flag_wr_clr;

    // Decode the write strobes.
    always_comb begin
        clr_pulse   = wr_en && wr_data[CLR_BIT];
        sel_change  = wr_en && (wr_data[SEL_W-1:0] != sel_q);
        flag_wr_clr = wr_en && !wr_data[FLAG_BIT];
    end

    // Hold enable and select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= SEL_OFF;
        end else if (wr_en) begin
            en_q  <= wr_data[EN_BIT];
            sel_q <= sel_e'(wr_data[SEL_W-1:0]);
        end
    end

    // Sticky flag: a hardware set wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (flag_wr_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Assemble the read view; reserved and clear bits read zero.
    always_comb begin
        rd_data                = '0;
        rd_data[SEL_W-1:0]     = sel_q;
        rd_data[EN_BIT]        = en_q;
        rd_data[FLAG_BIT]      = flag_q;
    end

    assign en   = en_q;
    assign sel  = sel_q;
    assign flag = flag_q;

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q);
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_wr_clr) |=> flag_q);
    a_r5_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_clr && !set_evt) |=> !flag_q);
endmodule

// File: rtl/rt_interval_timer.sv
// Periodic interrupt timer top: control register, fractional lower divider and
// pulse-counting upper stage. Assumes tick_en is a single-cycle enable.
module rt_interval_timer
    import rtit_pkg::*;
#(
    parameter int unsigned BASE_DIV = 19,
    parameter int unsigned SEQ_LEN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] ctrl_wdata,
    output logic [DATA_W-1:0] ctrl_rdata,
    output logic              irq
);
    logic            en;
    sel_e            sel;
    logic            clr_pulse;
    logic            sel_change;
    logic            p_base;
    logic            p_pair;
    logic            up_run;
    logic            up_done;
    logic            set_evt;
    logic [UP_W-1:0] up_tc;

    rtit_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctrl_we),
        .wr_data    (ctrl_wdata),
        .set_evt    (set_evt),
        .en         (en),
        .sel        (sel),
        .flag       (irq),
        .clr_pulse  (clr_pulse),
        .sel_change (sel_change),
        .rd_data    (ctrl_rdata)
    );

    rtit_frac_div #(
        .BASE_DIV (BASE_DIV),
        .SEQ_LEN  (SEQ_LEN)
    ) u_lower (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (en),
        .clr     (clr_pulse),
        .p_base  (p_base),
        .p_pair  (p_pair)
    );

    // Upper stage runs only while enabled with a long-interval code.
    always_comb begin
        up_run = en && (sel >= SEL_400U);
        up_tc  = upper_tc(sel);
    end

    rtit_interval_cnt #(
        .MAX_TC (UP_MAX_TC)
    ) u_upper (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (p_base),
        .run      (up_run),
        .restart  (clr_pulse || sel_change),
        .tc       (up_tc),
        .done     (up_done)
    );

    // Route the expiry source that matches the selected interval.
    always_comb begin
        case (sel)
            SEL_OFF:  set_evt = 1'b0;
            SEL_100U: set_evt = p_base;
            SEL_200U: set_evt = p_pair;
            default:  set_evt = up_done;
        endcase
    end

    a_r1_rise_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(en) && $past(sel) != SEL_OFF));
    a_r7_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick_en));
endmodule

// File: tb/tb_rt_interval_timer.sv
module tb_rt_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic [7:0] ctrl_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    rt_interval_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_rdata (ctrl_rdata),
        .irq        (irq)
    );

    // {select, first interval ticks, second interval ticks}
    localparam int VEC[7][3] = '{
        '{1, 19, 19},
        '{2, 38, 37},
        '{3, 75, 75},
        '{4, 150, 150},
        '{5, 188, 187},
        '{6, 375, 375},
        '{7, 938, 937}
    };

    function automatic logic [7:0] mk(input bit en, input bit clr, input bit flg, input int sel);
        mk = {1'b0, flg, clr, en, 1'b0, 3'(sel)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        ctrl_we = 1'b1;
        ctrl_wdata = d;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic do_tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic count_to_irq(input int limit, output int n);
        n = 0;
        while (n < limit && !irq) begin
            do_tick();
            n++;
        end
    endtask

    initial begin
        int n;
        do_reset();
        // R10: reset state
        check("R10 rdata", ctrl_rdata, 0);
        check("R10 irq", irq, 0);

        // R1 R2 R3 R4: interval table walked by one loop
        for (int v = 0; v < 7; v++) begin
            do_reset();
            wr(mk(1, 0, 0, VEC[v][0]));
            count_to_irq(2000, n);
            check($sformatf("R1/R4 first sel=%0d", VEC[v][0]), n, VEC[v][1]);
            wr(mk(1, 0, 0, VEC[v][0]));
            check("R5 sw clear", irq, 0);
            count_to_irq(2000, n);
            check($sformatf("R2/R3 second sel=%0d", VEC[v][0]), n, VEC[v][2]);
        end

        // R9: reserved bits read zero, clear reads zero, flag write 1 no effect
        do_reset();
        wr(8'hFF);
        check("R9 reserved", ctrl_rdata, 8'h17);

        // R1: code 0 never raises irq
        do_reset();
        wr(mk(1, 0, 0, 0));
        ticks(200);
        check("R1 off code", irq, 0);

        // R7: pause and resume
        do_reset();
        wr(mk(1, 0, 0, 1));
        ticks(10);
        wr(mk(0, 0, 0, 1));
        ticks(20);
        check("R7 paused", irq, 0);
        wr(mk(1, 0, 0, 1));
        count_to_irq(100, n);
        check("R7 resume", n, 9);

        // R8: clear restarts lower stage, reads zero
        do_reset();
        wr(mk(1, 0, 0, 1));
        ticks(10);
        wr(mk(1, 1, 0, 1));
        check("R8 clr reads 0", ctrl_rdata, 8'h11);
        count_to_irq(100, n);
        check("R8 lower clear", n, 19);

        // R8: clear restarts upper stage too
        do_reset();
        wr(mk(1, 0, 0, 3));
        ticks(50);
        wr(mk(1, 1, 0, 3));
        count_to_irq(200, n);
        check("R8 upper clear", n, 75);

        // R5: sticky flag, write 1 keeps it, write 0 clears it
        do_reset();
        wr(mk(1, 0, 0, 1));
        count_to_irq(100, n);
        ticks(30);
        check("R5 sticky", irq, 1);
        wr(mk(1, 0, 1, 1));
        check("R5 write one keeps", irq, 1);
        check("R5 rdata flag", ctrl_rdata, 8'h51);
        wr(mk(1, 0, 0, 1));
        check("R5 write zero clears", irq, 0);

        // R6: set beats a same-cycle clear
        do_reset();
        wr(mk(1, 0, 0, 1));
        ticks(18);
        check("R6 before expiry", irq, 0);
        tick_en = 1'b1;
        ctrl_we = 1'b1;
        ctrl_wdata = mk(1, 0, 0, 1);
        @(negedge clk);
        tick_en = 1'b0;
        ctrl_we = 1'b0;
        check("R6 set wins", irq, 1);

        // R11: select change restarts the upper count
        do_reset();
        wr(mk(1, 0, 0, 4));
        ticks(100);
        check("R11 no early irq", irq, 0);
        wr(mk(1, 0, 0, 3));
        count_to_irq(300, n);
        check("R11 full new interval", n, 69);

        done_flag = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done_flag && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule